// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs the external bus cycles of a small 8-bit microcontroller core. The core keeps its instruction space and its external data space apart. Each space is addressed with 16 bits, so each holds up to 64K bytes. The core issues one of three request kinds:

- an instruction fetch with a 16-bit address;
- a data read or write with a 16-bit address;
- a data read or write with an 8-bit address.

The sequencer turns each accepted request into a fixed sequence of bus states. It puts the address out on the pins, pulses the address latch enable and drives the strobe for the access. It then moves data over the shared low port and hands any byte it read back to the core.

The low address byte and the data byte share one 8-bit port. In this block that port is split into an output byte, an output-enable and an input byte. The upper address byte appears on a separate port, but only for 16-bit accesses. At all other times that port shows the value of the core's port latch. Instruction fetches are qualified by their own active-low enable strobe. Data accesses use separate active-low read and write strobes.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held, and after it is released, the outputs are `psen_n`=1, `rd_n`=1, `wr_n`=1, `ale`=0, `busy`=0, `ad_oe`=0 and `rd_valid`=0, and `hi_addr` follows `p2_sfr`.
- R2: A request seen at a clock edge while idle starts a cycle. In the following cycle (cycle 1), `ale` is high for exactly one cycle and `ad_out` shows the low address byte with `ad_oe`=1. `busy` is high in cycles 1 through 5 and low again in cycle 6.
- R3: In cycle 2 `ale` has fallen, while `ad_out` still shows the low address byte and `ad_oe` stays 1. An external latch clocked by the falling edge of `ale` therefore captures `{hi_addr, low address}`.
- R4: A fetch (`req_kind`=2'b00) drives `psen_n` low in cycles 3 and 4 only. `rd_n` and `wr_n` stay high for the whole cycle, and `req_write` is ignored.
- R5: A data read (`req_kind` 2'b01 or 2'b10 with `req_write`=0) drives `rd_n` low in cycles 3 and 4, while `psen_n` and `wr_n` stay high. `ad_oe` is 0 in cycles 3 to 5, which releases the port.
- R6: A data write (`req_kind` 2'b01 or 2'b10 with `req_write`=1) drives `wr_n` low in cycles 3 and 4, while `psen_n` and `rd_n` stay high. `ad_out` carries the write byte with `ad_oe`=1 in cycles 3 to 5.
- R7: For a fetch or read, `ad_in` is sampled at the edge where the strobe rises, which ends cycle 4. In cycle 5 `rd_valid` is 1 for one cycle and `rd_data` holds the sampled byte.
- R8: For `req_kind` 2'b00 or 2'b01, `hi_addr` equals address bits [15:8] in cycles 1 to 5. For `req_kind` 2'b10 (and the spare code 2'b11, treated the same way), `hi_addr` keeps the `p2_sfr` value.
- R9: A request presented while `busy` is 1 is dropped. No new `ale` pulse follows it, and the next cycle can start only from a request seen once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 fetch, 01 data 16-bit address, 10/11 data 8-bit address |
| req_write | input | 1 | Data write when 1 (ignored for fetch) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to write |
| p2_sfr | input | 8 | Port latch value shown on the high port when it is not carrying an address |
| busy | output | 1 | Bus cycle in progress |
| rd_valid | output | 1 | One-cycle pulse with a fetched or read byte |
| rd_data | output | 8 | Fetched or read byte |
| ad_out | output | 8 | Multiplexed port, output byte |
| ad_oe | output | 1 | Multiplexed port output enable |
| ad_in | input | 8 | Multiplexed port, input byte |
| hi_addr | output | 8 | High address port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The pins are a combinational decode of the state register, so every pin result is due in a fixed cycle counted from the edge that sees the request. That is cycle 1 for `ale`, cycles 3–4 for the strobes, cycle 5 for `rd_valid` and cycle 6 for idle. Each scenario task raises the request before that edge and then samples every pin at the falling clock edge of cycles 1 through 6, each against its own expected value for that cycle. A small memory model latches the address on the falling edge of `ale` and drives `ad_in` only while a read strobe is low. This way the returned byte proves both the latch timing and the sampling edge.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    K_FETCH  = 2'b00,
    K_DATA16 = 2'b01,
    K_DATA8  = 2'b10,
    K_SPARE  = 2'b11
  } acc_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_HOLD = 3'd2,
    ST_STRB = 3'd3,
    ST_DATA = 3'd4,
    ST_END  = 3'd5
  } bus_st_t;
endpackage

// File: rtl/ebs_fsm.sv
module ebs_fsm
  import ebs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  output logic    accept,
  output bus_st_t state
);
  bus_st_t state_q, state_d;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign state  = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_HOLD;
      ST_HOLD: state_d = ST_STRB;
      ST_STRB: state_d = ST_DATA;
      ST_DATA: state_d = ST_END;
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ebs_req_latch.sv
module ebs_req_latch
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              is_fetch,
  output logic              is_wide,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  acc_kind_t kind_in;
  logic fetch_d, wide_d, write_d;

  always_comb begin
    kind_in = acc_kind_t'(req_kind);
    fetch_d = (kind_in == K_FETCH);
    wide_d  = (kind_in == K_FETCH) || (kind_in == K_DATA16);
    write_d = req_write && !fetch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_fetch <= 1'b0;
      is_wide  <= 1'b0;
      is_write <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      is_fetch <= fetch_d;
      is_wide  <= wide_d;
      is_write <= write_d;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
    end
  end
endmodule

// File: rtl/ebs_rd_capture.sv
module ebs_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (cap_en) rd_data <= ad_in;
  end
endmodule

// File: rtl/ebs_pin_mux.sv
module ebs_pin_mux
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  bus_st_t           state,
  input  logic              is_fetch,
  input  logic              is_wide,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [HI_W-1:0]   p2_sfr,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_addr,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic in_cycle, addr_ph, strb_ph, data_ph;

  always_comb begin
    in_cycle = (state != ST_IDLE);
    addr_ph  = (state == ST_ADDR) || (state == ST_HOLD);
    strb_ph  = (state == ST_STRB) || (state == ST_DATA);
    data_ph  = strb_ph || (state == ST_END);

    ale     = (state == ST_ADDR);
    psen_n  = !(strb_ph && is_fetch);
    rd_n    = !(strb_ph && !is_fetch && !is_write);
    wr_n    = !(strb_ph && is_write);
    hi_addr = (in_cycle && is_wide) ? addr_q[ADDR_W-1:DATA_W] : p2_sfr;

    if (addr_ph) begin
      ad_out = addr_q[DATA_W-1:0];
      ad_oe  = 1'b1;
    end else if (data_ph && is_write) begin
      ad_out = wdata_q;
      ad_oe  = 1'b1;
    end else begin
      ad_out = '0;
      ad_oe  = 1'b0;
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [HI_W-1:0]   p2_sfr,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   hi_addr,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       accept, is_fetch, is_wide, is_write;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  bus_st_t    state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ebs_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid),
    .accept(accept), .state(state)
  );

  ebs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_sync_n), .accept(accept),
    .req_kind(req_kind), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .is_fetch(is_fetch), .is_wide(is_wide),
    .is_write(is_write), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  ebs_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_sync_n),
    .cap_en((state == ST_DATA) && !is_write),
    .ad_in(ad_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  ebs_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .state(state), .is_fetch(is_fetch), .is_wide(is_wide),
    .is_write(is_write), .addr_q(addr_q), .wdata_q(wdata_q),
    .p2_sfr(p2_sfr), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  assign busy = (state != ST_IDLE);

  // R4
  psen_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !psen_n |-> (rd_n && wr_n));

  // R5
  port_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_n || !psen_n) |-> !ad_oe);

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ale |=> (!ale && busy));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(ale) |-> ($stable(ad_out) && ad_oe));

  // R7
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_valid |-> ($past(!rd_n || !psen_n) && rd_n && psen_n));

  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ale |-> !$past(busy));
endmodule

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic [7:0]  p2_sfr = 8'hC3;
  logic        busy, rd_valid, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0]  rd_data, ad_out, ad_in, hi_addr;
  logic [15:0] lat_addr = 16'h0;
  logic [7:0]  wcap = 8'h0;
  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ext_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .p2_sfr(p2_sfr), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [7:0] pval(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] dval(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h33;
  endfunction

  // external memory model
  always @(negedge ale) lat_addr = {hi_addr, ad_out};
  always @(posedge wr_n) wcap = ad_out;
  assign ad_in = !psen_n ? pval(lat_addr) : (!rd_n ? dval(lat_addr) : 8'h00);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk({psen_n, rd_n, wr_n} == 3'b111, req, {psen_n, rd_n, wr_n}, 3'b111);
    chk({ale, busy, ad_oe, rd_valid} == 4'b0, req, {ale, busy, ad_oe, rd_valid}, 0);
    chk(hi_addr == p2_sfr, req, hi_addr, p2_sfr);
  endtask

  task automatic run_access(input logic [1:0] kind, input bit wr,
                            input logic [15:0] addr, input logic [7:0] wd,
                            input bit poke);
    bit wide, eff_wr;
    logic [7:0] hi_exp, rexp;
    logic [15:0] lat_exp;
    logic [2:0] strb_on;
    wide    = (kind == 2'b00) || (kind == 2'b01);
    eff_wr  = wr && (kind != 2'b00);
    hi_exp  = wide ? addr[15:8] : p2_sfr;
    lat_exp = {hi_exp, addr[7:0]};
    rexp    = (kind == 2'b00) ? pval(lat_exp) : dval(lat_exp);
    strb_on = (kind == 2'b00) ? 3'b011 : (eff_wr ? 3'b110 : 3'b101);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_write = wr;
    req_addr = addr; req_wdata = wd;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (poke && k >= 2 && k <= 4) begin
        // R9: second request while busy must be dropped
        req_valid = 1'b1; req_kind = 2'b01; req_write = 1'b1;
        req_addr = 16'hBEEF; req_wdata = 8'hEE;
      end
      case (k)
        1: begin
          chk(ale && busy, "R2", {ale, busy}, 2'b11);
          chk(ad_oe && ad_out == addr[7:0], "R2", ad_out, addr[7:0]);
          chk({psen_n, rd_n, wr_n} == 3'b111, "R2", {psen_n, rd_n, wr_n}, 3'b111);
          chk(hi_addr == hi_exp, "R8", hi_addr, hi_exp);
        end
        2: begin
          chk(!ale && busy, "R3", {ale, busy}, 2'b01);
          chk(ad_oe && ad_out == addr[7:0], "R3", ad_out, addr[7:0]);
          chk({psen_n, rd_n, wr_n} == 3'b111, "R3", {psen_n, rd_n, wr_n}, 3'b111);
        end
        3, 4: begin
          chk({psen_n, rd_n, wr_n} == strb_on,
              kind == 2'b00 ? "R4" : (eff_wr ? "R6" : "R5"),
              {psen_n, rd_n, wr_n}, strb_on);
          chk(hi_addr == hi_exp, "R8", hi_addr, hi_exp);
          if (eff_wr) chk(ad_oe && ad_out == wd, "R6", ad_out, wd);
          else        chk(!ad_oe, "R5", ad_oe, 0);
        end
        5: begin
          chk(busy && {psen_n, rd_n, wr_n} == 3'b111, "R2", {busy, psen_n, rd_n, wr_n}, 4'hF);
          chk(lat_addr == lat_exp, "R3", lat_addr, lat_exp);
          chk(hi_addr == hi_exp, "R8", hi_addr, hi_exp);
          if (eff_wr) begin
            chk(ad_oe && ad_out == wd, "R6", ad_out, wd);
            chk(wcap == wd, "R6", wcap, wd);
            chk(!rd_valid, "R6", rd_valid, 0);
          end else begin
            chk(rd_valid && rd_data == rexp, "R7", rd_data, rexp);
            chk(!ad_oe, "R5", ad_oe, 0);
          end
        end
        default: begin
          chk(!busy && !rd_valid, "R2", {busy, rd_valid}, 0);
          if (!eff_wr) chk(rd_data == rexp, "R7", rd_data, rexp);
        end
      endcase
    end
    if (poke) begin
      for (int j = 0; j < 2; j++) begin
        @(negedge clk);
        chk(!ale && !busy && wr_n, "R9", {ale, busy, wr_n}, 3'b001);
      end
    end
  endtask

  initial begin
    #1;
    check_idle("R1");
    repeat (4) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");
    // R4: fetch, write flag set but ignored
    run_access(2'b00, 1'b0, 16'h1234, 8'h00, 1'b0);
    run_access(2'b00, 1'b1, 16'hFF01, 8'h99, 1'b0);
    // R5 R8: 16-bit read, 8-bit read
    run_access(2'b01, 1'b0, 16'hA55A, 8'h00, 1'b0);
    run_access(2'b10, 1'b0, 16'h7F80, 8'h00, 1'b0);
    // R6: 16-bit write, 8-bit write, spare code
    run_access(2'b01, 1'b1, 16'h0042, 8'h3C, 1'b0);
    run_access(2'b10, 1'b1, 16'hAA11, 8'hC5, 1'b0);
    p2_sfr = 8'h5E;
    run_access(2'b11, 1'b0, 16'h00FE, 8'h00, 1'b0);
    // R9: requests during busy dropped
    run_access(2'b00, 1'b0, 16'h4000, 8'h00, 1'b1);
    run_access(2'b01, 1'b0, 16'h0000, 8'h00, 1'b0);
    check_idle("R1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule